// File: doc/BRIEF.md
# Upper Memory Shadow Region Decoder

This block steers every memory cycle that falls in the 384 KB upper memory window (0xA0000 to 0xFFFFF). The cycle goes either to internal DRAM, which holds the shadow copy, or out to the external bus. The window is split into 24 segments of 16 KB each.

Each segment owns a 2-bit control field. Read steering and write steering are set independently. This allows a ROM image to be copied into DRAM, since reads go external while writes go internal, and then run from DRAM, since reads go internal.

Software reaches the control bytes through an index/data register pair. The memory-side decode is purely combinational from the address and the read and write strobes, and yields four select lines. Two summary flags tell whether any segment at or above 0xE0000 has shadow read enabled, and whether any has shadow write enabled.

Top module: `shadow_map_ctrl`

## Requirements
- R1: After reset the index register and every control byte read back 0x00, both summary flags are low, and every window segment routes reads and writes to the external bus.
- R2: A write with `cfg_sel`=0 loads the index register, and a read with `cfg_sel`=0 returns it unchanged.
- R3: A data write (`cfg_sel`=1) to index 0x0D..0x12 stores all 8 bits, which read back through the data port. The new routing is in effect from the clock edge that accepts the write.
- R4: Control byte at index 0x0D+n, bits [2k+1:2k], governs the segment whose base is 0xA0000 + n*0x10000 + k*0x4000, for n in 0..5 and k in 0..3. This holds for every address inside that 16 KB segment.
- R5: Within a field, bit 1 set sends reads to internal memory and clear sends them external. Bit 0 set sends writes to internal memory and clear sends them external.
- R6: Addresses below 0xA0000 select internal memory for both reads and writes, whatever the control bytes hold.
- R7: While `mem_rd` is high exactly one of `sel_int_rd`/`sel_ext_rd` is high, and both are low while `mem_rd` is low. The same holds for `mem_wr` with `sel_int_wr`/`sel_ext_wr`.
- R8: `bios_shadow_rd` is high exactly when some segment at or above 0xE0000 (bytes at 0x11 and 0x12) has field bit 1 set.
- R9: `bios_shadow_wr` is high exactly when some segment at or above 0xE0000 has field bit 0 set.
- R10: A data write to index 0x07 replaces bits 7 and 5..0 and leaves stored bit 6 unchanged. Bit 6 resets to 0, so it always reads 0.
- R11: Data writes to any other index are dropped. Those indices read 0x00, and routing is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe, one byte per cycle |
| cfg_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_wdata | input | 8 | Write data for the selected port |
| cfg_rdata | output | 8 | Index register or the indexed control byte |
| mem_addr | input | 20 | Memory cycle address |
| mem_rd | input | 1 | Memory read cycle in progress |
| mem_wr | input | 1 | Memory write cycle in progress |
| sel_int_rd | output | 1 | Read served by internal DRAM |
| sel_ext_rd | output | 1 | Read forwarded to external bus |
| sel_int_wr | output | 1 | Write served by internal DRAM |
| sel_ext_wr | output | 1 | Write forwarded to external bus |
| bios_shadow_rd | output | 1 | Some segment at or above 0xE0000 reads internally |
| bios_shadow_wr | output | 1 | Some segment at or above 0xE0000 writes internally |

## Verification
The assertions assume that the memory and configuration inputs are at known 0/1 values on every sampled edge once reset has been released. They also assume that a configuration write is presented for a single cycle with a stable index already in place.

The bench holds every input at a defined level from time zero. It changes inputs only at falling clock edges and keeps all traffic idle until the internal reset release has passed, so no property samples an undefined or mid-change value.

// File: rtl/shadow_pkg.sv
`timescale 1ns/1ps
package shadow_pkg;
  localparam int unsigned CFG_W        = 8;
  localparam int unsigned ADDR_W       = 20;
  localparam int unsigned FIELD_W      = 2;
  localparam int unsigned SEG_REGS     = 6;
  localparam int unsigned SEGS_PER_REG = CFG_W / FIELD_W;
  localparam int unsigned SEG_COUNT    = SEG_REGS * SEGS_PER_REG;
  localparam int unsigned SEG_IDX_W    = $clog2(SEG_COUNT);
  localparam int unsigned SEG_SHIFT    = 14;
  localparam int unsigned FIELDS_W     = SEG_COUNT * FIELD_W;

  localparam logic [ADDR_W-1:0] WIN_BASE  = 20'hA0000;
  localparam logic [ADDR_W-1:0] BIOS_BASE = 20'hE0000;
  localparam logic [ADDR_W-1:0] WIN_SPAN  = ADDR_W'(SEG_COUNT << SEG_SHIFT);
  localparam int unsigned BIOS_FIRST_SEG  = int'((BIOS_BASE - WIN_BASE) >> SEG_SHIFT);

  localparam logic [CFG_W-1:0] SEG_IDX0  = 8'h0D;
  localparam logic [CFG_W-1:0] MISC_IDX  = 8'h07;
  localparam logic [CFG_W-1:0] MISC_KEEP = 8'h40;

  typedef logic [FIELD_W-1:0] seg_field_t;

  typedef struct packed {
    logic int_rd;
    logic ext_rd;
    logic int_wr;
    logic ext_wr;
  } mem_sel_t;
endpackage

// File: rtl/shadow_rst_sync.sv
`timescale 1ns/1ps
module shadow_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/shadow_cfg_regs.sv
`timescale 1ns/1ps
module shadow_cfg_regs
  import shadow_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_sel,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  output logic [FIELDS_W-1:0] seg_fields
);
  logic [CFG_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic [CFG_W-1:0] misc_q, misc_d;
  logic             misc_en;
  logic             data_wr;
  logic [SEG_REGS*CFG_W-1:0] seg_flat;
  logic [CFG_W-1:0] data_mux;

  // index port
  always_comb begin
    idx_en = cfg_wr & ~cfg_sel;
    idx_d  = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign data_wr = cfg_wr & cfg_sel;

  // misc byte with a protected bit
  always_comb begin
    misc_en = data_wr & (idx_q == MISC_IDX);
    misc_d  = (misc_q & MISC_KEEP) | (cfg_wdata & ~MISC_KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       misc_q <= '0;
    else if (misc_en) misc_q <= misc_d;
  end

  // segment control bytes
  for (genvar r = 0; r < SEG_REGS; r++) begin : g_seg
    localparam logic [CFG_W-1:0] MY_IDX = CFG_W'(SEG_IDX0 + r);
    logic [CFG_W-1:0] q;
    logic [CFG_W-1:0] d;
    logic             en;

    always_comb begin
      en = data_wr & (idx_q == MY_IDX);
      d  = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign seg_flat[r*CFG_W +: CFG_W] = q;

    assert_seg_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel && idx_q == MY_IDX) |=> (q == $past(cfg_wdata)));
  end

  assign seg_fields = seg_flat;

  // read mux
  always_comb begin
    data_mux = '0;
    if (idx_q == MISC_IDX) data_mux = misc_q;
    for (int r = 0; r < SEG_REGS; r++) begin
      if (idx_q == CFG_W'(SEG_IDX0 + r)) data_mux = seg_flat[r*CFG_W +: CFG_W];
    end
  end

  assign cfg_rdata = cfg_sel ? data_mux : idx_q;

  assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && !cfg_sel) |=> $stable(idx_q));

  assert_misc_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel && idx_q == MISC_IDX) |=>
      ((misc_q & MISC_KEEP) == $past(misc_q & MISC_KEEP)));
endmodule

// File: rtl/shadow_seg_decode.sv
`timescale 1ns/1ps
module shadow_seg_decode
  import shadow_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rd,
  input  logic                mem_wr,
  input  logic [FIELDS_W-1:0] seg_fields,
  output mem_sel_t            sel
);
  logic [ADDR_W-1:0]    win_off;
  logic                 in_win;
  logic [SEG_IDX_W-1:0] seg_idx;
  seg_field_t           field;
  logic                 rd_int, wr_int;

  always_comb begin
    win_off = mem_addr - WIN_BASE;
    in_win  = (mem_addr >= WIN_BASE) && (win_off < WIN_SPAN);
    seg_idx = win_off[SEG_SHIFT +: SEG_IDX_W];
  end

  always_comb begin
    field = '0;
    for (int s = 0; s < SEG_COUNT; s++) begin
      if (seg_idx == SEG_IDX_W'(s)) field = seg_fields[s*FIELD_W +: FIELD_W];
    end
  end

  always_comb begin
    rd_int = in_win ? field[1] : 1'b1;
    wr_int = in_win ? field[0] : 1'b1;
    sel.int_rd = mem_rd &  rd_int;
    sel.ext_rd = mem_rd & ~rd_int;
    sel.int_wr = mem_wr &  wr_int;
    sel.ext_wr = mem_wr & ~wr_int;
  end

  assert_rd_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $onehot({sel.int_rd, sel.ext_rd}));
  assert_wr_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $onehot({sel.int_wr, sel.ext_wr}));
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !mem_wr) |-> ($countones(sel) == 0));
  assert_low_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr < WIN_BASE) |-> (sel.int_rd == mem_rd && sel.int_wr == mem_wr));
endmodule

// File: rtl/shadow_bios_summary.sv
`timescale 1ns/1ps
module shadow_bios_summary
  import shadow_pkg::*;
(
  input  logic [FIELDS_W-1:0] seg_fields,
  output logic                bios_rd,
  output logic                bios_wr
);
  always_comb begin
    bios_rd = 1'b0;
    bios_wr = 1'b0;
    for (int s = BIOS_FIRST_SEG; s < SEG_COUNT; s++) begin
      bios_rd = bios_rd | seg_fields[s*FIELD_W + 1];
      bios_wr = bios_wr | seg_fields[s*FIELD_W];
    end
  end
endmodule

// File: rtl/shadow_map_ctrl.sv
`timescale 1ns/1ps
module shadow_map_ctrl
  import shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic              sel_int_rd,
  output logic              sel_ext_rd,
  output logic              sel_int_wr,
  output logic              sel_ext_wr,
  output logic              bios_shadow_rd,
  output logic              bios_shadow_wr
);
  logic                rst_sync_n;
  logic [FIELDS_W-1:0] seg_fields;
  mem_sel_t            sel;

  shadow_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  shadow_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .seg_fields (seg_fields)
  );

  shadow_seg_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .seg_fields (seg_fields),
    .sel        (sel)
  );

  shadow_bios_summary u_bios (
    .seg_fields (seg_fields),
    .bios_rd    (bios_shadow_rd),
    .bios_wr    (bios_shadow_wr)
  );

  assign sel_int_rd = sel.int_rd;
  assign sel_ext_rd = sel.ext_rd;
  assign sel_int_wr = sel.int_wr;
  assign sel_ext_wr = sel.ext_wr;

  assert_bios_rd_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_rd && mem_addr >= BIOS_BASE && sel_int_rd) |-> bios_shadow_rd);
  assert_bios_wr_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_wr && mem_addr >= BIOS_BASE && sel_int_wr) |-> bios_shadow_wr);
endmodule

// File: tb/shadow_map_ctrl_tb_top.sv
`timescale 1ns/1ps
module shadow_map_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [19:0] mem_addr = 20'h0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic        sel_int_rd, sel_ext_rd, sel_int_wr, sel_ext_wr;
  logic        bios_shadow_rd, bios_shadow_wr;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_seg [6];

  always #2.5 clk = ~clk;

  shadow_map_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .sel_int_rd(sel_int_rd),
    .sel_ext_rd(sel_ext_rd), .sel_int_wr(sel_int_wr), .sel_ext_wr(sel_ext_wr),
    .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic port_wr(input logic sel, input logic [7:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] data);
    port_wr(1'b0, idx);
    port_wr(1'b1, data);
    if (idx >= 8'h0D && idx <= 8'h12) m_seg[idx - 8'h0D] = data;
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] val);
    port_wr(1'b0, idx);
    cfg_sel = 1'b1;
    #1 val = cfg_rdata;
    cfg_sel = 1'b0;
  endtask

  // expected {int_rd, ext_rd, int_wr, ext_wr}
  function automatic logic [3:0] exp_sel(input int addr, input logic rd, input logic wr);
    logic rint, wint;
    int seg;
    logic [1:0] f;
    if (addr < 'hA0000) begin
      rint = 1'b1; wint = 1'b1;
    end else begin
      seg = (addr - 'hA0000) >> 14;
      f = 2'((m_seg[seg / 4] >> (2 * (seg % 4))) & 8'h3);
      rint = f[1]; wint = f[0];
    end
    return {rd & rint, rd & ~rint, wr & wint, wr & ~wint};
  endfunction

  task automatic mem_chk(input string req, input int addr, input logic rd, input logic wr);
    @(negedge clk);
    mem_addr = 20'(addr); mem_rd = rd; mem_wr = wr;
    #1 chk(req, $sformatf("sel @%05h rd=%0b wr=%0b", addr, rd, wr),
           int'({sel_int_rd, sel_ext_rd, sel_int_wr, sel_ext_wr}), int'(exp_sel(addr, rd, wr)));
    mem_rd = 1'b0; mem_wr = 1'b0;
  endtask

  task automatic flags_chk(input string req);
    logic [7:0] hi;
    hi = m_seg[4] | m_seg[5];
    @(negedge clk);
    chk(req, "bios_shadow_rd", int'(bios_shadow_rd), int'((hi & 8'hAA) != 0));
    chk(req, "bios_shadow_wr", int'(bios_shadow_wr), int'((hi & 8'h55) != 0));
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 24; s++) begin
      mem_chk(req, 'hA0000 + s * 'h4000, 1'b1, 1'b0);
      mem_chk(req, 'hA0000 + s * 'h4000 + 'h3FFF, 1'b0, 1'b1);
      mem_chk(req, 'hA0000 + s * 'h4000 + 'h1234, 1'b1, 1'b1);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1 chk("R1", "index after reset", int'(cfg_rdata), 0);
    for (int i = 'h0D; i <= 'h12; i++) begin
      reg_rd(8'(i), v);
      chk("R1", $sformatf("byte %0h after reset", i), int'(v), 0);
    end
    reg_rd(8'h07, v);
    chk("R1", "misc after reset", int'(v), 0);
    flags_chk("R1");
    sweep("R1");
  endtask

  task automatic t_index();
    logic [7:0] v;
    port_wr(1'b0, 8'h5A);
    #1 v = cfg_rdata;
    chk("R2", "index readback 5A", int'(v), 'h5A);
    port_wr(1'b0, 8'hC3);
    #1 v = cfg_rdata;
    chk("R2", "index readback C3", int'(v), 'hC3);
  endtask

  task automatic t_store();
    logic [7:0] v;
    for (int i = 0; i < 6; i++) begin
      reg_wr(8'(8'h0D + i), 8'(8'h3C + 8'h11 * i));
      mem_chk("R3", 'hA0000 + i * 'h10000 + 'h8000, 1'b1, 1'b1);
    end
    for (int i = 0; i < 6; i++) begin
      reg_rd(8'(8'h0D + i), v);
      chk("R3", $sformatf("byte %0h readback", 8'h0D + i), int'(v), int'(8'(8'h3C + 8'h11 * i)));
    end
  endtask

  task automatic t_map();
    logic [7:0] pats [6] = '{8'hE4, 8'h1B, 8'h55, 8'hAA, 8'h00, 8'hFF};
    for (int rot = 0; rot < 2; rot++) begin
      for (int i = 0; i < 6; i++) reg_wr(8'(8'h0D + i), pats[(i + rot * 3) % 6]);
      sweep("R4 R5");
    end
  endtask

  task automatic t_outside();
    for (int i = 0; i < 6; i++) reg_wr(8'(8'h0D + i), 8'h00);
    mem_chk("R6", 'h00000, 1'b1, 1'b1);
    mem_chk("R6", 'h9FFFF, 1'b1, 1'b1);
    mem_chk("R6", 'hA0000, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) reg_wr(8'(8'h0D + i), 8'hFF);
    mem_chk("R6", 'h9FFFF, 1'b1, 1'b1);
    mem_chk("R6", 'h12345, 1'b0, 1'b1);
  endtask

  task automatic t_idle();
    reg_wr(8'h0F, 8'h1B);
    mem_chk("R7", 'hC0000, 1'b0, 1'b0);
    mem_chk("R7", 'h50000, 1'b0, 1'b0);
    mem_chk("R7", 'hC4000, 1'b1, 1'b0);
    mem_chk("R7", 'hCC000, 1'b0, 1'b1);
  endtask

  task automatic t_bios();
    for (int i = 0; i < 6; i++) reg_wr(8'(8'h0D + i), 8'h00);
    flags_chk("R8 R9");
    reg_wr(8'h10, 8'hFF);
    flags_chk("R8 R9");
    reg_wr(8'h11, 8'h08);
    flags_chk("R8");
    reg_wr(8'h11, 8'h00);
    reg_wr(8'h12, 8'h40);
    flags_chk("R9");
    reg_wr(8'h11, 8'h02);
    flags_chk("R8 R9");
    mem_chk("R8", 'hF0000, 1'b1, 1'b1);
  endtask

  task automatic t_misc();
    logic [7:0] v;
    reg_wr(8'h07, 8'hFF);
    reg_rd(8'h07, v);
    chk("R10", "misc after FF", int'(v), 'hBF);
    reg_wr(8'h07, 8'h41);
    reg_rd(8'h07, v);
    chk("R10", "misc after 41", int'(v), 'h01);
    mem_chk("R10", 'hE8000, 1'b1, 1'b1);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    reg_wr(8'h08, 8'hFF);
    reg_wr(8'h13, 8'hFF);
    reg_wr(8'h0C, 8'hFF);
    reg_rd(8'h13, v);
    chk("R11", "idx 13 read", int'(v), 0);
    reg_rd(8'h0C, v);
    chk("R11", "idx 0C read", int'(v), 0);
    reg_rd(8'h08, v);
    chk("R11", "idx 08 read", int'(v), 0);
    sweep("R11");
    flags_chk("R11");
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) m_seg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_index();
    t_store();
    t_map();
    t_outside();
    t_idle();
    t_bios();
    t_misc();
    t_unused();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule